// File: doc/BRIEF.md
# Instruction-Phased Serial Register Port

This block is a synchronous serial slave that gives an external host read and write access to a bank of twelve configuration registers of different widths. Every communication cycle begins with an 8-bit instruction. The instruction carries the transfer direction and the register address. A data phase follows it, and its length is set by the addressed register. The block runs on the chip's system clock. It oversamples the serial clock, chip select, IO reset and serial data input through a synchronizer chain, then acts on the detected serial clock edges.

Writes leave the block on a valid/ready stream (`wr_valid`, `wr_ready`, `wr_addr`, `wr_data`). A write is offered only after its final data bit has arrived. `wr_valid` and its payload then stay unchanged until the bank raises `wr_ready`. The serial side cannot be stalled, so back-pressure never slows the serial clock. If a second write finishes while the first is still waiting, the newer one replaces it. A host that leaves at least one instruction phase between writes never meets this case. Reads use a plain combinational lookup: the block drives `rd_addr`, and the bank returns `rd_data` in the same cycle, right-aligned.

Bit order (`lsb_first`) and pin mode (`three_wire`) are static configuration inputs. Change them only while no cycle is in progress.

Top module: `sp_serial_port`

## Requirements
- R1: After reset both output enables (`sdio_oe`, `sdo_oe`) are low and `wr_valid` is low.
- R2: The first eight rising serial clock edges of a cycle form the instruction byte. Bit 7 = 1 selects a read and 0 selects a write. Bits 3:0 are the register address. Bits 6:4 have no effect. No output is driven during the instruction.
- R3: The data phase length is 2 bytes for addresses 0, 1, 8, 9, 10 and 11. It is 6 bytes for addresses 2, 3 and 4, 4 bytes for addresses 5 and 7, and 3 bytes for address 6.
- R4: A write is presented on `wr_valid`/`wr_addr`/`wr_data` only after all of its bits have arrived. The data is right-aligned. While `wr_ready` is low, `wr_valid` stays high and the address and data stay stable.
- R5: With `lsb_first` = 0, the instruction and the whole register travel most significant bit first. With `lsb_first` = 1, both travel least significant bit first. Either order reaches the same register value.
- R6: Read data changes only after falling serial clock edges. With `three_wire` = 1 it appears on `sdio_out` with `sdio_oe` high and `sdo_oe` low. With `three_wire` = 0 it appears on `sdo` with `sdo_oe` high and `sdio_oe` low.
- R7: A high `io_reset` ends the cycle at once and discards any partial write. The next eight rising edges after it falls form a new instruction.
- R8: A high `cs_n` acts like `io_reset`: both output enables go low and the next cycle starts with an instruction.
- R9: Addresses 12 to 15 take a single data byte. A write to them produces no `wr_valid`, and a read returns zero whatever `rd_data` holds.
- R10: When the last data bit of a cycle arrives, the next eight rising edges form a new instruction, even with `cs_n` held low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_reset | input | 1 | Active-high cycle abort |
| sdio_in | input | 1 | Serial data input (pad input of the shared data pin) |
| sdio_out | output | 1 | Read data toward the shared data pin |
| sdio_oe | output | 1 | Output enable of the shared data pin |
| sdo | output | 1 | Read data on the dedicated output pin |
| sdo_oe | output | 1 | Output enable of the dedicated output pin |
| lsb_first | input | 1 | 1 = least significant bit first, 0 = most significant bit first |
| three_wire | input | 1 | 1 = read data on the shared pin, 0 = on the dedicated pin |
| wr_valid | output | 1 | Completed write is offered |
| wr_ready | input | 1 | Register bank accepts the offered write |
| wr_addr | output | 4 | Address of the offered write |
| wr_data | output | 48 | Right-aligned data of the offered write |
| rd_addr | output | 4 | Address of the register being read |
| rd_data | input | 48 | Right-aligned contents of the register at `rd_addr` |

## Verification
The bench builds the port with three synchronizer stages, the deepest it is expected to use. The serial clock half period is eight system clocks, so the path from synchronizer to launched bit is tested with only a few cycles of margin. At that rate, 48-bit registers fit easily in both bit orders, and aborts can land mid-instruction as well as mid-data. Back-pressure lasting many serial clock periods and several back-to-back cycles inside one chip-select window are also within reach.

// File: rtl/sp_port_pkg.sv
package sp_port_pkg;
  localparam int ADDR_W    = 4;
  localparam int MAX_BYTES = 6;
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int NUM_REGS  = 12;
  localparam int CNT_W     = $clog2(DATA_W);

  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;

  // data-phase byte count per register address; unmapped addresses take one dummy byte
  function automatic logic [2:0] reg_bytes(input logic [ADDR_W-1:0] a);
    case (a)
      4'd2, 4'd3, 4'd4:         return 3'd6;
      4'd5, 4'd7:               return 3'd4;
      4'd6:                     return 3'd3;
      4'd0, 4'd1, 4'd8, 4'd9,
      4'd10, 4'd11:             return 3'd2;
      default:                  return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sp_serial_core.sv
module sp_serial_core
  import sp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              abort,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_bit,
  output logic              tx_en,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  logic              sclk_q;
  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  last_bit;
  logic [7:0]        instr;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              load_q;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_sh;

  logic              rise, fall;
  logic [7:0]        instr_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CNT_W-1:0]  last_nxt;
  logic [DATA_W-1:0] rx_nxt;
  logic [CNT_W-1:0]  pad_bits;
  logic [DATA_W-1:0] load_val;
  logic              mapped;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign instr_nxt = lsb_first ? {sdi_s, instr[7:1]} : {instr[6:0], sdi_s};
  assign addr_nxt  = instr_nxt[ADDR_W-1:0];
  assign last_nxt  = CNT_W'({reg_bytes(addr_nxt), 3'b000} - 6'd1);
  assign rx_nxt    = lsb_first ? {sdi_s, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], sdi_s};
  assign pad_bits  = CNT_W'(DATA_W - 1) - last_bit;
  assign mapped    = addr_q < ADDR_W'(NUM_REGS);
  assign load_val  = mapped ? rd_data : '0;
  assign rd_addr   = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      phase       <= PH_INSTR;
      bit_cnt     <= '0;
      last_bit    <= '0;
      instr       <= '0;
      addr_q      <= '0;
      rd_q        <= 1'b0;
      load_q      <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_bit      <= 1'b0;
      tx_en       <= 1'b0;
      commit      <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      commit <= 1'b0;
      load_q <= 1'b0;
      if (abort) begin
        phase   <= PH_INSTR;
        bit_cnt <= '0;
        tx_en   <= 1'b0;
      end else begin
        if (rise) begin
          if (phase == PH_INSTR) begin
            instr <= instr_nxt;
            if (bit_cnt == CNT_W'(7)) begin
              phase    <= PH_DATA;
              bit_cnt  <= '0;
              addr_q   <= addr_nxt;
              rd_q     <= instr_nxt[7];
              load_q   <= instr_nxt[7];
              last_bit <= last_nxt;
              rx_sh    <= '0;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end else begin
            rx_sh <= rx_nxt;
            if (bit_cnt == last_bit) begin
              phase       <= PH_INSTR;
              bit_cnt     <= '0;
              tx_en       <= 1'b0;
              commit      <= ~rd_q & mapped;
              commit_addr <= addr_q;
              commit_data <= lsb_first ? (rx_nxt >> pad_bits) : rx_nxt;
            end else begin
              bit_cnt <= bit_cnt + CNT_W'(1);
            end
          end
        end
        // read data is staged one clock after the instruction, launched on falling edges
        if (load_q) begin
          tx_en <= 1'b1;
          tx_sh <= lsb_first ? load_val : (load_val << pad_bits);
        end else if (fall && tx_en) begin
          tx_bit <= lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
          tx_sh  <= lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
        end
      end
    end
  end
endmodule

// File: rtl/sp_wr_hold.sv
module sp_wr_hold
  import sp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [DATA_W-1:0] commit_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (commit) begin
      wr_valid <= 1'b1;
      wr_addr  <= commit_addr;
      wr_data  <= commit_data;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_serial_port.sv
module sp_serial_port
  import sp_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              io_reset,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              lsb_first,
  input  logic              three_wire,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic [3:0]        pins_s;
  logic              sclk_s, sdi_s, cs_n_s, io_reset_s, abort_s;
  logic              tx_bit, tx_en;
  logic              core_commit;
  logic [ADDR_W-1:0] core_addr;
  logic [DATA_W-1:0] core_data;

  sp_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk, sdio_in, cs_n, io_reset}),
    .q    (pins_s)
  );

  assign {sclk_s, sdi_s, cs_n_s, io_reset_s} = pins_s;
  assign abort_s = cs_n_s | io_reset_s;

  sp_serial_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .abort      (abort_s),
    .lsb_first  (lsb_first),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .tx_bit     (tx_bit),
    .tx_en      (tx_en),
    .commit     (core_commit),
    .commit_addr(core_addr),
    .commit_data(core_data)
  );

  sp_wr_hold u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (core_commit),
    .commit_addr(core_addr),
    .commit_data(core_data),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  assign sdio_out = tx_bit;
  assign sdo      = tx_bit;
  assign sdio_oe  = tx_en & three_wire;
  assign sdo_oe   = tx_en & ~three_wire;
endmodule

// File: rtl/sp_serial_port_checker.sv
module sp_serial_port_checker
  import sp_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              commit,
  input logic              three_wire,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  // R4: an offered write waits unchanged for the bank
  a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !commit) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R6: never both pins driven
  a_r6_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sdio_oe, sdo_oe}));

  // R6: the dedicated pin is used only in two-pin mode
  a_r6_sdo_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !three_wire);

  // R6: the shared pin drives only in single-pin mode
  a_r6_sdio_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> three_wire);

  // R8: deselect or abort releases both pins
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sdio_oe && !sdo_oe));

  // R7: an aborted cycle commits nothing
  a_r7_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !commit);

  // R9: unmapped addresses never reach the write stream
  a_r9_mapped_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr < ADDR_W'(NUM_REGS)));
endmodule

bind sp_serial_port sp_serial_port_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .abort     (abort_s),
  .commit    (core_commit),
  .three_wire(three_wire),
  .sdio_oe   (sdio_oe),
  .sdo_oe    (sdo_oe),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/sp_serial_port_bench.sv
module sp_serial_port_bench;
  import sp_port_pkg::*;

  localparam int HALF     = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, io_reset = 1'b0, sdio_in = 1'b0;
  logic lsb_first = 1'b0, three_wire = 1'b1, wr_ready = 1'b1;
  logic sdio_out, sdio_oe, sdo, sdo_oe, wr_valid;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  logic [DATA_W-1:0] bank [16];
  assign rd_data = bank[rd_addr];

  typedef struct packed {logic [3:0] a; logic [47:0] d;} wr_t;
  wr_t exp_q[$];

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  sp_serial_port #(.SYNC_STAGES(3)) u_sp_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io_reset(io_reset),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .lsb_first(lsb_first), .three_wire(three_wire),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string msg, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic int model_bytes(input logic [3:0] a);
    if (a >= 4'd12) return 1;
    if (a == 4'd6) return 3;
    if (a == 4'd5 || a == 4'd7) return 4;
    if (a >= 4'd2 && a <= 4'd4) return 6;
    return 2;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write stream monitor: sampled at the edge the design sees
  always @(posedge clk) begin
    wr_t e;
    cyc++;
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 write offered with none outstanding", wr_data, '0);
      end else begin
        e = exp_q.pop_front();
        check(wr_addr == e.a && wr_data == e.d, "R4 write address and data", {44'd0, wr_addr} ^ wr_data, {44'd0, e.a} ^ e.d);
      end
      bank[wr_addr] = wr_data;
    end
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic shift_bits(input int n, input logic [47:0] v, input bit exp_oe,
                            output logic [47:0] got, output int oe_bad);
    got = '0;
    oe_bad = 0;
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = lsb_first ? i : n - 1 - i;
      sdio_in = v[idx];
      tick(HALF);
      got[idx] = three_wire ? sdio_out : sdo;
      if (exp_oe) begin
        if (!(three_wire ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe))) oe_bad++;
      end else if (sdio_oe || sdo_oe) begin
        oe_bad++;
      end
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input bit rd, input logic [3:0] a, input logic [2:0] junk,
                      input logic [47:0] wd, input string tag);
    logic [47:0] got, mask, expv;
    int bad, nbits;
    nbits = 8 * model_bytes(a);
    mask = (nbits == 48) ? '1 : ((48'd1 << nbits) - 48'd1);
    shift_bits(8, {40'd0, rd, junk, a}, 1'b0, got, bad);
    check(bad == 0, {tag, " R2 no drive during instruction"}, 48'(bad), 48'd0);
    if (rd) begin
      expv = (a < 4'd12) ? (bank[a] & mask) : '0;
      shift_bits(nbits, '0, 1'b1, got, bad);
      check(bad == 0, {tag, " R6 output enable on selected pin"}, 48'(bad), 48'd0);
      check(got == expv, {tag, " read data"}, got, expv);
    end else begin
      if (a < 4'd12) exp_q.push_back({a, wd & mask});
      shift_bits(nbits, wd, 1'b0, got, bad);
      check(bad == 0, {tag, " R2 no drive during write data"}, 48'(bad), 48'd0);
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic close_frame();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  initial begin
    logic [47:0] got, wd;
    int bad;
    for (int i = 0; i < 16; i++) bank[i] = (i < 12) ? '0 : 48'hDEAD_BEEF_CAFE;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1
    check(!sdio_oe && !sdo_oe, "R1 output enables after reset", {46'd0, sdio_oe, sdo_oe}, 48'd0);
    check(!wr_valid, "R1 write stream idle after reset", {47'd0, wr_valid}, 48'd0);

    // R3: every register written then read, most significant bit first
    for (int a = 0; a < 12; a++) begin
      open_frame();
      xfer(1'b0, 4'(a), 3'd0, 48'h9A3C_5E71_B2D4 ^ (48'(a) * 48'h0F1E_2D3C_4B5A), "R3 write length");
      close_frame();
    end
    for (int a = 0; a < 12; a++) begin
      open_frame();
      xfer(1'b1, 4'(a), 3'd0, '0, "R3 read length");
      close_frame();
    end

    // R2: bits 6:4 of the instruction ignored
    open_frame();
    xfer(1'b0, 4'd5, 3'b101, 48'h0000_1357_9BDF, "R2 junk bits write");
    close_frame();
    open_frame();
    xfer(1'b1, 4'd5, 3'b010, '0, "R2 junk bits read");
    close_frame();

    // R10: back-to-back cycles in one select window
    open_frame();
    xfer(1'b0, 4'd6, 3'd0, 48'h0000_00A1_B2C3, "R10 chained write");
    xfer(1'b1, 4'd6, 3'd0, '0, "R10 chained read");
    xfer(1'b0, 4'd1, 3'd7, 48'h0000_0000_E00F, "R10 chained write");
    xfer(1'b1, 4'd1, 3'd0, '0, "R10 chained read");
    close_frame();

    // R5: least significant bit first, crossing orders
    lsb_first = 1'b1;
    open_frame();
    xfer(1'b0, 4'd2, 3'd0, 48'h8001_2345_6781, "R5 lsb-first write");
    xfer(1'b1, 4'd2, 3'd0, '0, "R5 lsb-first read");
    xfer(1'b0, 4'd7, 3'd0, 48'h0000_C0DE_0003, "R5 lsb-first write");
    xfer(1'b1, 4'd6, 3'd0, '0, "R5 lsb-first read of msb-first data");
    close_frame();
    lsb_first = 1'b0;
    open_frame();
    xfer(1'b1, 4'd2, 3'd0, '0, "R5 msb-first read of lsb-first data");
    xfer(1'b1, 4'd7, 3'd0, '0, "R5 msb-first read of lsb-first data");
    close_frame();

    // R6: two-pin mode
    three_wire = 1'b0;
    open_frame();
    xfer(1'b1, 4'd3, 3'd0, '0, "R6 two-pin read");
    xfer(1'b1, 4'd4, 3'd0, '0, "R6 two-pin read");
    xfer(1'b1, 4'd10, 3'd0, '0, "R6 two-pin read");
    xfer(1'b1, 4'd12, 3'd0, '0, "R9 two-pin read unmapped");
    close_frame();
    three_wire = 1'b1;

    // R9: unmapped addresses
    open_frame();
    xfer(1'b0, 4'd13, 3'd0, 48'h0000_0000_00A5, "R9 unmapped write");
    xfer(1'b1, 4'd13, 3'd0, '0, "R9 unmapped read zero");
    xfer(1'b1, 4'd0, 3'd0, '0, "R9 framing after dummy byte");
    xfer(1'b0, 4'd15, 3'd3, 48'h0000_0000_00FF, "R9 unmapped write");
    close_frame();
    tick(20);
    check(exp_q.size() == 0, "R9 no write offered for unmapped address", 48'(exp_q.size()), 48'd0);

    // R7: abort mid-data, then mid-instruction
    open_frame();
    shift_bits(8, {40'd0, 8'h02}, 1'b0, got, bad);
    shift_bits(20, 48'hFFFF_FFFF_FFFF, 1'b0, got, bad);
    io_reset = 1'b1;
    tick(6);
    io_reset = 1'b0;
    tick(HALF);
    xfer(1'b1, 4'd2, 3'd0, '0, "R7 read after aborted write");
    shift_bits(5, 48'h1F, 1'b0, got, bad);
    io_reset = 1'b1;
    tick(6);
    io_reset = 1'b0;
    tick(HALF);
    xfer(1'b1, 4'd0, 3'd0, '0, "R7 read after aborted instruction");
    close_frame();

    // R8: deselect during read data
    open_frame();
    shift_bits(8, {40'd0, 8'h84}, 1'b0, got, bad);
    shift_bits(12, '0, 1'b1, got, bad);
    cs_n = 1'b1;
    tick(6);
    check(!sdio_oe && !sdo_oe, "R8 pins released on deselect", {46'd0, sdio_oe, sdo_oe}, 48'd0);
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    xfer(1'b1, 4'd5, 3'd0, '0, "R8 fresh instruction after deselect");
    close_frame();

    // R4: write offered only after the last bit, held under back-pressure
    wr_ready = 1'b0;
    wd = 48'h0000_0000_6C3A;
    open_frame();
    shift_bits(8, {40'd0, 8'h09}, 1'b0, got, bad);
    shift_bits(15, wd >> 1, 1'b0, got, bad);
    tick(6);
    check(!wr_valid, "R4 no write before final bit", {47'd0, wr_valid}, 48'd0);
    exp_q.push_back({4'd9, wd});
    shift_bits(1, wd, 1'b0, got, bad);
    close_frame();
    tick(40);
    check(wr_valid && wr_addr == 4'd9 && wr_data == wd, "R4 write held while not ready",
          wr_data, wd);
    wr_ready = 1'b1;
    tick(4);
    check(!wr_valid, "R4 write released after ready", {47'd0, wr_valid}, 48'd0);
    open_frame();
    xfer(1'b1, 4'd9, 3'd0, '0, "R4 read back accepted write");
    close_frame();

    tick(50);
    check(exp_q.size() == 0, "R4 every expected write delivered", 48'(exp_q.size()), 48'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule